// File: doc/BRIEF.md
# Streaming Zero-Padding Framer

This block turns a continuous stream of samples into fixed-length frames for a transform stage. Each frame holds a group of `DLEN` received samples, in the order they arrived, followed by `NPAD` words of zero. Incoming samples are stored in a two-port buffer, which is split into two halves used alternately. The writer fills one half at the input rate while the reader drains the other half at one word per clock.

The input may present at most one sample every two clocks. With the default `NPAD = DLEN`, the reader produces `DLEN + NPAD` words in the time `DLEN` samples arrive, so the padding is inserted by a change of rate rather than by stalling the source.

The input side is valid/ready. A sample transfers on a clock where both `in_valid` and `in_ready` are high. `in_ready` falls only when the half the writer would fill next still holds a group the reader has not finished. The output side has no ready: once a frame starts it runs to its end on consecutive clocks, and the consumer must accept one word per clock.

Top module: `zero_pad_framer`

## Requirements
- R1: Each output frame is `DLEN` stored samples in arrival order, followed by `NPAD` words that are all zero bits (`FRAME = DLEN + NPAD` words).
- R2: `out_sof` is high only on frame word index 0, and `out_eof` is high only on word index `FRAME-1`. Both are high only together with `out_valid`.
- R3: No output word appears until a complete group of `DLEN` samples has been accepted. A partial group produces no output, however long it waits.
- R4: Within a frame, `out_valid` is high on every clock from `out_sof` through `out_eof`.
- R5: No accepted sample is lost or overwritten. At most `2*DLEN` accepted samples are ever held. `in_ready` is low while the half the writer targets is still held for reading.
- R6: A synchronous active-high reset clears the write and read counters, the half selects and the held-group flags. After reset, `out_valid` is low and `in_ready` is high.
- R7: If the next group is not complete when a frame ends, `out_valid` stays low until that group is complete. The following frame then starts again at word index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample offered (at most every second clock) |
| in_ready | output | 1 | Buffer can take the offered sample |
| in_data | input | W | Input sample |
| out_valid | output | 1 | Output word present |
| out_sof | output | 1 | First word of a frame |
| out_eof | output | 1 | Last word of a frame |
| out_data | output | W | Output word (zero in the padding region) |

## Verification
The bench first offers a partial group and then waits. This separates a design that holds output until a group is complete from one that leaks early words. Next it streams several groups at the nominal one-sample-per-two-clocks rate. Every sample value differs from its neighbours, so a swapped half, an off-by-one address or a misplaced pad boundary shows as a data mismatch against the scoreboard. A final group arrives slowly, which forces an idle gap between frames and shows whether the next frame restarts cleanly at index 0.

// File: rtl/zp_pkg.sv
package zp_pkg;

  // Per-word frame markers produced by the reader, aligned with buffer read data.
  typedef struct packed {
    logic valid;
    logic sof;
    logic eof;
    logic zero;
  } zp_mark_t;

endpackage

// File: rtl/zp_buffer.sv
module zp_buffer #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] mem [DEPTH];

  // One write port and one registered read port.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/zp_writer.sv
module zp_writer #(
  parameter int unsigned DLEN = 64,
  localparam int unsigned AW  = $clog2(DLEN)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [1:0]  held,
  output logic        in_ready,
  output logic        wr_en,
  output logic [AW:0] wr_addr,
  output logic        fill_done,
  output logic        wr_half
);

  logic [AW-1:0] wr_idx;
  logic          last;

  assign in_ready  = ~held[wr_half];
  assign wr_en     = in_valid & in_ready;
  assign last      = (wr_idx == AW'(DLEN - 1));
  assign fill_done = wr_en & last;
  assign wr_addr   = {wr_half, wr_idx};

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx  <= '0;
      wr_half <= 1'b0;
    end else if (wr_en) begin
      if (last) begin
        wr_idx  <= '0;
        wr_half <= ~wr_half;
      end else begin
        wr_idx <= wr_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/zp_reader.sv
module zp_reader
  import zp_pkg::*;
#(
  parameter int unsigned DLEN  = 64,
  parameter int unsigned NPAD  = 64,
  localparam int unsigned FRAME = DLEN + NPAD,
  localparam int unsigned AW    = $clog2(DLEN),
  localparam int unsigned CW    = $clog2(FRAME)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  held,
  output logic [AW:0] rd_addr,
  output logic        frame_done,
  output logic        rd_half,
  output zp_mark_t    mark
);

  logic          active;
  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last    = (cnt == CW'(FRAME - 1));
  assign frame_done = active & at_last;
  assign rd_addr    = {rd_half, cnt[AW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      cnt     <= '0;
      rd_half <= 1'b0;
      mark    <= '0;
    end else begin
      // Markers line up with the registered buffer read of the same address.
      mark.valid <= active;
      mark.sof   <= active & (cnt == '0);
      mark.eof   <= active & at_last;
      mark.zero  <= (cnt >= CW'(DLEN));
      if (!active) begin
        if (held[rd_half]) begin
          active <= 1'b1;
          cnt    <= '0;
        end
      end else if (at_last) begin
        cnt     <= '0;
        rd_half <= ~rd_half;
        active  <= held[~rd_half];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/zero_pad_framer.sv
module zero_pad_framer
  import zp_pkg::*;
#(
  parameter int unsigned W    = 16,
  parameter int unsigned DLEN = 64,
  parameter int unsigned NPAD = 64,
  localparam int unsigned AW  = $clog2(DLEN)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic         out_sof,
  output logic         out_eof,
  output logic [W-1:0] out_data
);

  logic [1:0]  held;
  logic        wr_en, fill_done, wr_half;
  logic [AW:0] wr_addr, rd_addr;
  logic        frame_done, rd_half;
  logic [W-1:0] rd_data;
  zp_mark_t    mark;

  zp_writer #(.DLEN(DLEN)) u_writer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .held(held),
    .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr),
    .fill_done(fill_done), .wr_half(wr_half)
  );

  zp_buffer #(.W(W), .DEPTH(2*DLEN)) u_buffer (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(in_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  zp_reader #(.DLEN(DLEN), .NPAD(NPAD)) u_reader (
    .clk(clk), .rst(rst), .held(held), .rd_addr(rd_addr),
    .frame_done(frame_done), .rd_half(rd_half), .mark(mark)
  );

  // A half is held from its last write until the reader finishes its frame.
  for (genvar h = 0; h < 2; h++) begin : g_held
    always_ff @(posedge clk) begin
      if (rst) begin
        held[h] <= 1'b0;
      end else if (fill_done && (wr_half == 1'(h))) begin
        held[h] <= 1'b1;
      end else if (frame_done && (rd_half == 1'(h))) begin
        held[h] <= 1'b0;
      end
    end
  end

  assign out_valid = mark.valid;
  assign out_sof   = mark.sof;
  assign out_eof   = mark.eof;
  assign out_data  = (mark.valid && !mark.zero) ? rd_data : '0;

endmodule

// File: rtl/zp_checker.sv
module zp_checker #(
  parameter int unsigned W    = 16,
  parameter int unsigned DLEN = 64,
  parameter int unsigned NPAD = 64,
  localparam int unsigned FRAME = DLEN + NPAD,
  localparam int unsigned PW    = $clog2(FRAME) + 1,
  localparam int unsigned OW    = $clog2(2*DLEN) + 2
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_sof,
  input logic         out_eof,
  input logic [W-1:0] out_data
);

  logic [PW-1:0] pos;
  logic [OW-1:0] occ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      occ <= '0;
    end else begin
      if (out_valid) pos <= out_eof ? '0 : pos + 1'b1;
      occ <= occ + OW'(in_valid && in_ready) - ((out_valid && out_eof) ? OW'(DLEN) : '0);
    end
  end

  AST_SOF_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sof == (pos == '0)));                      // R2
  AST_EOF_AT_LAST: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_eof == (pos == PW'(FRAME - 1))));           // R2
  AST_MARK_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (out_sof || out_eof) |-> out_valid);                           // R2
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && pos >= PW'(DLEN)) |-> (out_data == '0));         // R1
  AST_FRAME_GAPLESS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_eof) |=> out_valid);                        // R4
  AST_NO_EARLY_FRAME: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sof) |-> (occ >= OW'(DLEN)));                // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    occ <= OW'(2*DLEN));                                           // R5

endmodule

bind zero_pad_framer zp_checker #(.W(W), .DLEN(DLEN), .NPAD(NPAD)) i_zp_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data)
);

// File: tb/test_zero_pad_framer.sv
`timescale 1ns/1ps
module test_zero_pad_framer;

  localparam int W     = 16;
  localparam int DLEN  = 64;
  localparam int NPAD  = 64;
  localparam int FRAME = DLEN + NPAD;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready, out_valid, out_sof, out_eof;
  logic [W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int outs_seen = 0;
  int frames_seen = 0;
  int mon_idx = 0;
  int sample_no = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] grp[$];

  always #5 clk = ~clk;

  zero_pad_framer #(.W(W), .DLEN(DLEN), .NPAD(NPAD)) i_zero_pad_framer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: offers samples at one per `gap` clocks, honouring in_ready,
  // and pushes each completed frame's expectation into the scoreboard.
  task automatic send(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = W'(sample_no * 37 + 11);
      @(posedge clk);
      grp.push_back(in_data);
      sample_no++;
      if (grp.size() == DLEN) begin
        foreach (grp[k]) exp_q.push_back(grp[k]);
        for (int z = 0; z < NPAD; z++) exp_q.push_back('0);
        grp.delete();
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  // Monitor: compares every output word with the scoreboard head.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      logic [W-1:0] e;
      outs_seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 output without complete group", outs_seen, 0);
      end else begin
        e = exp_q.pop_front();
        check(out_data == e, (mon_idx < DLEN) ? "R1 data word" : "R1 pad word",
              int'(out_data), int'(e));
      end
      check(out_sof == (mon_idx == 0), "R2 sof position", int'(out_sof), int'(mon_idx == 0));
      check(out_eof == (mon_idx == FRAME - 1), "R2 eof position", int'(out_eof),
            int'(mon_idx == FRAME - 1));
      if (mon_idx == FRAME - 1) begin
        mon_idx = 0;
        frames_seen++;
      end else begin
        mon_idx++;
      end
    end else if (!rst && mon_idx != 0) begin
      check(1'b0, "R4 gap inside frame", 0, 1);
    end
  end

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    repeat (4) @(negedge clk);
    // R6: reset state
    check(out_valid == 1'b0, "R6 out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R6 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R6 in_ready after reset", int'(in_ready), 1);

    // R3: partial group is held back
    send(DLEN - 1, 3);
    repeat (400) @(negedge clk);
    check(outs_seen == 0, "R3 no output for partial group", outs_seen, 0);

    // R1/R2/R4/R5: complete the group, then stream at nominal rate
    send(1 + 3 * DLEN, 2);

    // R7: slow group forces an idle gap, next frame restarts at index 0
    send(DLEN, 7);

    for (int t = 0; t < 2000 && exp_q.size() != 0; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(frames_seen == 5, "R7 frames after slow group", frames_seen, 5);
    check(exp_q.size() == 0, "R5 all accepted samples emitted", exp_q.size(), 0);
    check(out_valid == 1'b0, "R7 idle once groups used up", int'(out_valid), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule